// File: doc/BRIEF.md
# Dual-Lane One's-Complement Add Unit

This block carries out the add-family operations of a twin arithmetic datapath. Two 16-bit lanes, left and right, run side by side. Each lane has its own accumulator, A register, B register and overflow flag. Every command brings a 32-bit operand word. Its upper half-word belongs to the left lane and its lower half-word to the right lane. Twin operations instead present the upper half-word to both lanes. All arithmetic is one's complement with end-around carry, so both all-zeros (+0) and all-ones (−0) are legal values.

Commands arrive on a valid/ready stream. The unit completes any command in the cycle it is accepted, so `in_ready` is always high and the unit never applies back-pressure. A command takes effect on the rising edge where `in_valid` is high, and every register output shows the new value after that edge. Besides executing an operation, the stream can preset the A or B registers from the operand word, the way neighbouring instruction classes would write them. Operand fetch and instruction timing are handled outside.

Top module: `dl_add_unit`

## Requirements
- R1: After reset every accumulator, A register and B register reads +0 (0x0000) and both overflow flags read 0.
- R2: `in_ready` is always 1; with `in_valid` low no accumulator, A register or B register changes.
- R3: Command code `in_cmd`=00 executes `in_op`; op 0 loads each accumulator with its own half-word, op 4 loads each with the bitwise complement of its half-word; neither changes the A registers.
- R4: Op 1 adds each lane's half-word into its accumulator and op 5 subtracts it (adds its complement); both use end-around carry and set both A registers to +0.
- R5: Op 2 adds and op 6 subtracts the upper (left) half-word in both lanes; both set both A registers to +0.
- R6: Op 3 adds each lane's B register into its accumulator and sets both A registers to +0.
- R7: Op 7 loads each accumulator with the magnitude of its half-word (a negative value is complemented, so −0 gives +0) and sets both A registers to +0.
- R8: Op 8 copies each accumulator into its B register, then subtracts the half-word's magnitude from the accumulator, and sets both A registers to +0.
- R9: Ops 9 to 15 add the upper half-word into the left accumulator only, leave the right accumulator and right flag unchanged, and set both A registers to +0.
- R10: A lane's overflow flag is set when an adding operation (ops 1, 2, 3, 5, 6, 8 and 9 to 15) combines two values of equal sign into a result of the opposite sign. The flag stays set until `ovf_clr` is high on a rising edge, whether or not a command is accepted. An overflow in that same cycle leaves it set.
- R11: `in_cmd`=01 loads the A registers from the operand halves, `in_cmd`=10 loads the B registers from them, and `in_cmd`=11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Always 1; the unit accepts a command every cycle |
| in_cmd | input | 2 | 00 execute, 01 preset A, 10 preset B, 11 no effect |
| in_op | input | 4 | Add-family operation code |
| in_word | input | 32 | Operand; upper half to left lane, lower half to right lane |
| ovf_clr | input | 1 | Clears both overflow flags at the edge |
| acc_left_o | output | 16 | Left accumulator |
| acc_right_o | output | 16 | Right accumulator |
| areg_left_o | output | 16 | Left A register |
| areg_right_o | output | 16 | Right A register |
| breg_left_o | output | 16 | Left B register |
| breg_right_o | output | 16 | Right B register |
| ovf_left_o | output | 1 | Left sticky overflow |
| ovf_right_o | output | 1 | Right sticky overflow |

## Verification
The assertions check the rules that hold on every cycle, whatever the data: A registers clearing after operations that reset them, the B capture of the old accumulator for difference of magnitudes, flag stickiness and clearing, the stability of the right lane under unassigned codes, idle hold, and B presets. The actual one's-complement values are shown only by the bench's scenarios. These include end-around carry, −0 results, magnitudes of negative numbers and −0, twin broadcast, and overflow at the positive limit.

// File: rtl/dl_add_pkg.sv
package dl_add_pkg;

  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    CMD_EXEC  = 2'b00,
    CMD_SET_A = 2'b01,
    CMD_SET_B = 2'b10,
    CMD_NONE  = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ACC_KEEP     = 3'd0,
    ACC_OPND     = 3'd1,
    ACC_OPND_INV = 3'd2,
    ACC_MAG      = 3'd3,
    ACC_SUM      = 3'd4
  } acc_src_e;

  typedef enum logic [1:0] {
    ADDEND_OWN  = 2'd0,
    ADDEND_LEFT = 2'd1,
    ADDEND_BREG = 2'd2
  } addend_e;

  typedef struct packed {
    acc_src_e acc_src;
    addend_e  addend;
    logic     mag_add;
    logic     inv_add;
    logic     clr_a;
    logic     save_b;
    logic     right_hold;
  } lane_ctl_t;

endpackage

// File: rtl/dl_oc_adder.sv
module dl_oc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, x} + {1'b0, y};
    sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dl_add_decode.sv
module dl_add_decode
  import dl_add_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output lane_ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.acc_src = ACC_KEEP;
    ctl.addend  = ADDEND_OWN;
    case (op)
      4'd0: ctl.acc_src = ACC_OPND;
      4'd1: begin
        ctl.acc_src = ACC_SUM;
        ctl.clr_a   = 1'b1;
      end
      4'd2: begin
        ctl.acc_src = ACC_SUM;
        ctl.addend  = ADDEND_LEFT;
        ctl.clr_a   = 1'b1;
      end
      4'd3: begin
        ctl.acc_src = ACC_SUM;
        ctl.addend  = ADDEND_BREG;
        ctl.clr_a   = 1'b1;
      end
      4'd4: ctl.acc_src = ACC_OPND_INV;
      4'd5: begin
        ctl.acc_src = ACC_SUM;
        ctl.inv_add = 1'b1;
        ctl.clr_a   = 1'b1;
      end
      4'd6: begin
        ctl.acc_src = ACC_SUM;
        ctl.addend  = ADDEND_LEFT;
        ctl.inv_add = 1'b1;
        ctl.clr_a   = 1'b1;
      end
      4'd7: begin
        ctl.acc_src = ACC_MAG;
        ctl.clr_a   = 1'b1;
      end
      4'd8: begin
        ctl.acc_src = ACC_SUM;
        ctl.mag_add = 1'b1;
        ctl.inv_add = 1'b1;
        ctl.save_b  = 1'b1;
        ctl.clr_a   = 1'b1;
      end
      default: begin
        ctl.acc_src    = ACC_SUM;
        ctl.addend     = ADDEND_LEFT;
        ctl.right_hold = 1'b1;
        ctl.clr_a      = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dl_add_lane.sv
module dl_add_lane
  import dl_add_pkg::*;
#(
  parameter int W       = 16,
  parameter bit IS_LEFT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         set_a,
  input  logic         set_b,
  input  logic         ovf_clr,
  input  lane_ctl_t    ctl,
  input  logic [W-1:0] own_half,
  input  logic [W-1:0] left_half,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         ovf_o
);
  logic [W-1:0] acc_q, a_q, b_q;
  logic         ovf_q;
  logic [W-1:0] addend_raw, addend_mag, addend;
  logic [W-1:0] own_mag, sum, acc_d;
  logic         add_ovf, upd, ovf_set;

  always_comb begin
    case (ctl.addend)
      ADDEND_LEFT: addend_raw = left_half;
      ADDEND_BREG: addend_raw = b_q;
      default:     addend_raw = own_half;
    endcase
    addend_mag = addend_raw[W-1] ? ~addend_raw : addend_raw;
    addend     = ctl.mag_add ? addend_mag : addend_raw;
    if (ctl.inv_add) addend = ~addend;
  end

  dl_oc_adder #(.W(W)) u_adder (
    .x   (acc_q),
    .y   (addend),
    .sum (sum),
    .ovf (add_ovf)
  );

  assign own_mag = own_half[W-1] ? ~own_half : own_half;
  assign upd     = go && (IS_LEFT || !ctl.right_hold);
  assign ovf_set = upd && (ctl.acc_src == ACC_SUM) && add_ovf;

  always_comb begin
    case (ctl.acc_src)
      ACC_OPND:     acc_d = own_half;
      ACC_OPND_INV: acc_d = ~own_half;
      ACC_MAG:      acc_d = own_mag;
      ACC_SUM:      acc_d = sum;
      default:      acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (upd) acc_q <= acc_d;
      if (set_a) a_q <= own_half;
      else if (go && ctl.clr_a) a_q <= '0;
      if (set_b) b_q <= own_half;
      else if (upd && ctl.save_b) b_q <= acc_q;
      ovf_q <= (ovf_q && !ovf_clr) || ovf_set;
    end
  end

  assign acc_o = acc_q;
  assign a_o   = a_q;
  assign b_o   = b_q;
  assign ovf_o = ovf_q;

  // R4
  a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && ctl.clr_a |=> a_q == '0);

  // R8
  dim_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && ctl.save_b |=> b_q == $past(acc_q));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !ovf_clr |=> ovf_q);

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !(go && ctl.acc_src == ACC_SUM) |=> !ovf_q);

  // R9
  right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_LEFT && go && ctl.right_hold |=> $stable(acc_q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go && !set_a && !set_b |=> $stable(acc_q) && $stable(a_q) && $stable(b_q));
endmodule

// File: rtl/dl_add_unit.sv
module dl_add_unit
  import dl_add_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_cmd,
  input  logic [OP_W-1:0]     in_op,
  input  logic [2*HALF_W-1:0] in_word,
  input  logic                ovf_clr,
  output logic [HALF_W-1:0]   acc_left_o,
  output logic [HALF_W-1:0]   acc_right_o,
  output logic [HALF_W-1:0]   areg_left_o,
  output logic [HALF_W-1:0]   areg_right_o,
  output logic [HALF_W-1:0]   breg_left_o,
  output logic [HALF_W-1:0]   breg_right_o,
  output logic                ovf_left_o,
  output logic                ovf_right_o
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int LANES  = 2;

  lane_ctl_t         ctl;
  logic              go, set_a, set_b;
  logic [HALF_W-1:0] acc_v [LANES];
  logic [HALF_W-1:0] a_v   [LANES];
  logic [HALF_W-1:0] b_v   [LANES];
  logic              ovf_v [LANES];

  assign in_ready = 1'b1;
  assign go    = in_valid && (in_cmd == CMD_EXEC);
  assign set_a = in_valid && (in_cmd == CMD_SET_A);
  assign set_b = in_valid && (in_cmd == CMD_SET_B);

  dl_add_decode u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dl_add_lane #(.W(HALF_W), .IS_LEFT(g == 0)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .set_a     (set_a),
      .set_b     (set_b),
      .ovf_clr   (ovf_clr),
      .ctl       (ctl),
      .own_half  (in_word[WORD_W-1-g*HALF_W -: HALF_W]),
      .left_half (in_word[WORD_W-1 -: HALF_W]),
      .acc_o     (acc_v[g]),
      .a_o       (a_v[g]),
      .b_o       (b_v[g]),
      .ovf_o     (ovf_v[g])
    );
  end

  assign acc_left_o   = acc_v[0];
  assign acc_right_o  = acc_v[1];
  assign areg_left_o  = a_v[0];
  assign areg_right_o = a_v[1];
  assign breg_left_o  = b_v[0];
  assign breg_right_o = b_v[1];
  assign ovf_left_o   = ovf_v[0];
  assign ovf_right_o  = ovf_v[1];

  // R11
  setb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cmd == CMD_SET_B |=>
      breg_left_o == $past(in_word[WORD_W-1 -: HALF_W]) &&
      breg_right_o == $past(in_word[HALF_W-1:0]));

  // R11
  cmd_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cmd == CMD_NONE |=>
      $stable(acc_left_o) && $stable(acc_right_o) && $stable(areg_left_o) && $stable(breg_right_o));
endmodule

// File: tb/dl_add_unit_bench.sv
module dl_add_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_cmd = 2'b00;
  logic [3:0]  in_op = 4'd0;
  logic [31:0] in_word = 32'h0;
  logic        ovf_clr = 1'b0;
  logic [15:0] acc_l, acc_r, a_l, a_r, b_l, b_r;
  logic        ov_l, ov_r;

  int tests = 0;
  int fails = 0;

  logic [15:0] m_acc [2];
  logic [15:0] m_a   [2];
  logic [15:0] m_b   [2];
  logic        m_ovf [2];

  dl_add_unit u_dl_add_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_op(in_op), .in_word(in_word), .ovf_clr(ovf_clr),
    .acc_left_o(acc_l), .acc_right_o(acc_r), .areg_left_o(a_l), .areg_right_o(a_r),
    .breg_left_o(b_l), .breg_right_o(b_r), .ovf_left_o(ov_l), .ovf_right_o(ov_r)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [15:0] oc_add(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic oc_ovf(input logic [15:0] x, input logic [15:0] y);
    logic [15:0] r;
    r = oc_add(x, y);
    return (x[15] == y[15]) && (r[15] != x[15]);
  endfunction

  function automatic logic [15:0] mag(input logic [15:0] x);
    return x[15] ? ~x : x;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " acc_l"}, acc_l, m_acc[0]);
    chk({tag, " acc_r"}, acc_r, m_acc[1]);
    chk({tag, " a_l"}, a_l, m_a[0]);
    chk({tag, " a_r"}, a_r, m_a[1]);
    chk({tag, " b_l"}, b_l, m_b[0]);
    chk({tag, " b_r"}, b_r, m_b[1]);
    chk({tag, " ovf_l"}, {15'd0, ov_l}, {15'd0, m_ovf[0]});
    chk({tag, " ovf_r"}, {15'd0, ov_r}, {15'd0, m_ovf[1]});
  endtask

  task automatic model(input logic v, input logic [1:0] cmd, input logic [3:0] op,
                       input logic [31:0] w, input logic clr);
    logic [15:0] half [2];
    logic        fl [2];
    half[0] = w[31:16];
    half[1] = w[15:0];
    fl[0] = 1'b0;
    fl[1] = 1'b0;
    if (v && cmd == 2'b01) begin
      m_a[0] = half[0];
      m_a[1] = half[1];
    end else if (v && cmd == 2'b10) begin
      m_b[0] = half[0];
      m_b[1] = half[1];
    end else if (v && cmd == 2'b00) begin
      for (int i = 0; i < 2; i++) begin
        case (op)
          4'd0: m_acc[i] = half[i];
          4'd4: m_acc[i] = ~half[i];
          4'd7: begin m_acc[i] = mag(half[i]); m_a[i] = 16'h0; end
          4'd1: begin fl[i] = oc_ovf(m_acc[i], half[i]); m_acc[i] = oc_add(m_acc[i], half[i]); m_a[i] = 16'h0; end
          4'd5: begin fl[i] = oc_ovf(m_acc[i], ~half[i]); m_acc[i] = oc_add(m_acc[i], ~half[i]); m_a[i] = 16'h0; end
          4'd2: begin fl[i] = oc_ovf(m_acc[i], half[0]); m_acc[i] = oc_add(m_acc[i], half[0]); m_a[i] = 16'h0; end
          4'd6: begin fl[i] = oc_ovf(m_acc[i], ~half[0]); m_acc[i] = oc_add(m_acc[i], ~half[0]); m_a[i] = 16'h0; end
          4'd3: begin fl[i] = oc_ovf(m_acc[i], m_b[i]); m_acc[i] = oc_add(m_acc[i], m_b[i]); m_a[i] = 16'h0; end
          4'd8: begin
            m_b[i] = m_acc[i];
            fl[i] = oc_ovf(m_acc[i], ~mag(half[i]));
            m_acc[i] = oc_add(m_acc[i], ~mag(half[i]));
            m_a[i] = 16'h0;
          end
          default: begin
            if (i == 0) begin
              fl[0] = oc_ovf(m_acc[0], half[0]);
              m_acc[0] = oc_add(m_acc[0], half[0]);
            end
            m_a[i] = 16'h0;
          end
        endcase
      end
    end
    for (int i = 0; i < 2; i++) m_ovf[i] = (m_ovf[i] & ~clr) | fl[i];
  endtask

  task automatic step(input logic v, input logic [1:0] cmd, input logic [3:0] op,
                      input logic [31:0] w, input logic clr);
    @(negedge clk);
    in_valid = v;
    in_cmd   = cmd;
    in_op    = op;
    in_word  = w;
    ovf_clr  = clr;
    model(v, cmd, op, w, clr);
    @(negedge clk);
    in_valid = 1'b0;
    ovf_clr  = 1'b0;
  endtask

  task automatic exec(input logic [3:0] op, input logic [31:0] w);
    step(1'b1, 2'b00, op, w, 1'b0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin
      m_acc[i] = 16'h0; m_a[i] = 16'h0; m_b[i] = 16'h0; m_ovf[i] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    chk("R2 ready", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_load;
    step(1'b1, 2'b01, 4'd0, 32'h1111_2222, 1'b0);
    exec(4'd0, 32'h0003_0010);
    chk_all("R3 load");
    chk("R3 A kept", a_l, 16'h1111);
    exec(4'd4, 32'h00FF_0000);
    chk("R3 comp l", acc_l, 16'hFF00);
    chk("R3 comp r", acc_r, 16'hFFFF);
    chk_all("R3 comp");
  endtask

  task automatic t_addsub;
    exec(4'd0, 32'h0003_0010);
    step(1'b1, 2'b01, 4'd0, 32'hABCD_1234, 1'b0);
    exec(4'd1, 32'hFFFE_0005);
    chk("R4 endaround", acc_l, 16'h0002);
    chk("R4 add r", acc_r, 16'h0015);
    chk("R4 A clr", a_r, 16'h0000);
    exec(4'd5, 32'h0001_0015);
    chk("R4 negzero", acc_r, 16'hFFFF);
    chk_all("R4 sub");
  endtask

  task automatic t_twin;
    exec(4'd0, 32'h0002_0007);
    exec(4'd2, 32'h0003_0100);
    chk("R5 tad l", acc_l, 16'h0005);
    chk("R5 tad r", acc_r, 16'h000A);
    exec(4'd6, 32'h0001_7777);
    chk("R5 tsu r", acc_r, 16'h0009);
    chk_all("R5 twin");
  endtask

  task automatic t_dim_addb;
    exec(4'd0, 32'h0009_FFF0);
    step(1'b1, 2'b01, 4'd0, 32'h5555_AAAA, 1'b0);
    exec(4'd8, 32'hFFFD_0003);
    chk("R8 b_l", b_l, 16'h0009);
    chk("R8 acc_l", acc_l, 16'h0007);
    chk("R8 acc_r", acc_r, 16'hFFED);
    chk_all("R8 dim");
    step(1'b1, 2'b01, 4'd0, 32'h5555_AAAA, 1'b0);
    exec(4'd3, 32'hDEAD_BEEF);
    chk("R6 adb l", acc_l, 16'h0010);
    chk("R6 adb r", acc_r, 16'hFFDE);
    chk_all("R6 adb");
  endtask

  task automatic t_mag;
    step(1'b1, 2'b01, 4'd0, 32'h0F0F_F0F0, 1'b0);
    exec(4'd7, 32'h8000_0005);
    chk("R7 mag neg", acc_l, 16'h7FFF);
    chk("R7 mag pos", acc_r, 16'h0005);
    exec(4'd7, 32'hFFFF_0000);
    chk("R7 negzero", acc_l, 16'h0000);
    chk_all("R7 mag");
  endtask

  task automatic t_unassigned;
    for (int op = 9; op < 16; op++) begin
      step(1'b1, 2'b01, 4'd0, 32'h1234_5678, 1'b0);
      exec(4'd0, 32'h0001_0002);
      exec(op[3:0], 32'h0004_0009);
      chk("R9 left", acc_l, 16'h0005);
      chk("R9 right held", acc_r, 16'h0002);
      chk_all("R9 unassigned");
    end
  endtask

  task automatic t_overflow;
    step(1'b0, 2'b00, 4'd0, 32'h0, 1'b1);
    exec(4'd0, 32'h7FFF_0000);
    exec(4'd1, 32'h0001_0000);
    chk("R10 sum", acc_l, 16'h8000);
    chk("R10 ovf l", {15'd0, ov_l}, 16'd1);
    chk("R10 ovf r", {15'd0, ov_r}, 16'd0);
    exec(4'd0, 32'h0000_0000);
    chk("R10 sticky", {15'd0, ov_l}, 16'd1);
    step(1'b0, 2'b00, 4'd0, 32'h0, 1'b1);
    chk("R10 clear", {15'd0, ov_l}, 16'd0);
    exec(4'd0, 32'h7FFF_7FFF);
    step(1'b1, 2'b00, 4'd2, 32'h0002_0000, 1'b1);
    chk("R10 clr+set", {15'd0, ov_r}, 16'd1);
    chk_all("R10 ovf");
  endtask

  task automatic t_cmd_idle;
    step(1'b1, 2'b11, 4'd1, 32'h7FFF_7FFF, 1'b0);
    chk_all("R11 none");
    step(1'b1, 2'b10, 4'd0, 32'hCAFE_BEEF, 1'b0);
    chk("R11 setb", b_r, 16'hBEEF);
    chk_all("R11 setb");
    step(1'b0, 2'b00, 4'd1, 32'h1234_4321, 1'b0);
    chk_all("R2 idle");
  endtask

  initial begin
    t_reset();
    t_load();
    t_addsub();
    t_twin();
    t_dim_addb();
    t_mag();
    t_unassigned();
    t_overflow();
    t_cmd_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule